// File: doc/BRIEF.md
# Prescaled Eight-Bit PWM Generator

This block produces one pulse-width-modulated output, intended for loads such as a display backlight. Every output period spans 256 steps of an internal step counter. Each step lasts a power-of-two number of counting ticks. A 16-bit configuration word supplies three things: the duty compare value, a flag that chooses normal or inverted output, and the prescale code that sets the step length. A counting tick is either every system clock cycle or a single-cycle pulse from a slow tick source, chosen by a select input. The whole block runs in one clock domain.

Software starts the generator with a one-cycle start strobe and stops it with a separate one-cycle stop strobe, then polls a running status output. Status lags the command. After a start the block first waits in an arming state for the next counting tick. After a stop it finishes the period in progress in a draining state before it goes idle. Configuration changes are copied into a shadow register only at the start of a period, so a period is never cut short or glitched.

The controller has four states: IDLE, ARM, RUN and DRAIN. Its transitions are:

- IDLE to ARM on start without stop.
- ARM to IDLE on stop.
- ARM to RUN on a counting tick.
- RUN to DRAIN on stop.
- DRAIN to RUN on start without stop.
- DRAIN to IDLE at the end of a period.

Top module: `bklt_pwm_gen`

## Requirements
- R1: The configuration word carries the duty compare value in bits 15:8, the normal-polarity flag in bit 4 and the prescale code in bits 2:0. Bits 7:5 and 3 have no effect.
- R2: With prescale code p (0 to 6), a period lasts 256·2^p counting ticks, and the output is active for duty·2^p of them, at the start of the period.
- R3: Prescale codes 7 and above behave exactly like code 6.
- R4: The largest duty is 255/256. The output is inactive during the last step of every period, even with duty 255.
- R5: With the flag at 1 the output is high while active and low otherwise. With the flag at 0 the output is inverted.
- R6: After a start strobe the status output stays 0 while arming and rises at the next counting tick. In system-clock mode it reads 1 from the second clock edge after the strobe.
- R7: After a stop strobe the generator completes the current period. Status falls at the clock edge that ends that period, so it stays 1 for exactly 256·2^p·(ticks interval) cycles after a stop issued in the first cycle of a period.
- R8: A start strobe during draining cancels the stop and the generator keeps running. When both strobes arrive together, stop wins. A stop during arming returns to idle.
- R9: The select input at 1 makes every system clock cycle a counting tick. At 0 only cycles with the slow tick pulse count.
- R10: Changes to duty, polarity or prescale made during a period take effect only at the next period start.
- R11: While status is 0, the output sits at the inactive level of the live polarity flag (low when the flag is 1, high when it is 0), and the step and prescale counters are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 16 | Configuration: duty [15:8], normal-polarity flag [4], prescale code [2:0] |
| src_sys | input | 1 | Counting source select: 1 system clock, 0 slow tick |
| slow_tick | input | 1 | Single-cycle slow counting pulse |
| en_set | input | 1 | Start strobe, active for one cycle |
| en_clr | input | 1 | Stop strobe, active for one cycle |
| pwm_out | output | 1 | PWM waveform |
| running | output | 1 | Status: 1 while the generator runs or drains |

## Verification
The hardest situations to reach are the ones where a strobe or a configuration change lands partway through a period: a restart during draining, a simultaneous start and stop, and a duty rewrite mid-period. The bench reaches them by timing its strobes and writes against the clock edge at which status rises, which is the first cycle of a period. From that edge it counts samples exactly. A near-exhaustive sweep over duty edge values, all polarities and prescale codes 0 to 3 uses a stop issued in the first cycle of each period. That single period then measures the period length and the active count, and the stop latency, arithmetically. Prescale code 7 and the slow tick source take one period each.

// File: rtl/pwmg_pkg.sv
package pwmg_pkg;

    localparam int unsigned DUTY_W   = 8;
    localparam int unsigned PS_W     = 3;
    localparam int unsigned PS_MAX   = 6;
    localparam int unsigned CFG_W    = 16;
    localparam int unsigned DUTY_LSB = 8;
    localparam int unsigned POL_BIT  = 4;
    localparam int unsigned PRE_W    = PS_MAX;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } pwmg_state_e;

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        logic              pol;
        logic [PS_W-1:0]   ps;
    } pwmg_cfg_t;

    // Assemble a configuration, folding out-of-range prescale codes to the maximum.
    function automatic pwmg_cfg_t pwmg_make_cfg(input logic [DUTY_W-1:0] duty,
                                                input logic pol,
                                                input logic [PS_W-1:0] raw_ps);
        pwmg_cfg_t c;
        c.duty = duty;
        c.pol  = pol;
        c.ps   = (raw_ps > PS_W'(PS_MAX)) ? PS_W'(PS_MAX) : raw_ps;
        return c;
    endfunction

endpackage

// File: rtl/pwmg_ctrl.sv
module pwmg_ctrl
    import pwmg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_set,
    input  logic        en_clr,
    input  logic        base_tick,
    input  logic        wrap,
    output pwmg_state_e state_o,
    output logic        count_en,
    output logic        load_o,
    output logic        run_o
);

    pwmg_state_e state_q;
    pwmg_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_set && !en_clr) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (en_clr)         state_d = ST_IDLE;
                else if (base_tick) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (en_clr) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (en_set && !en_clr) state_d = ST_RUN;
                else if (wrap)         state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        count_en = (state_q == ST_RUN) || (state_q == ST_DRAIN);
        run_o    = count_en;
        load_o   = ((state_q == ST_ARM) && (state_d == ST_RUN)) ||
                   (wrap && (state_d != ST_IDLE));
        state_o  = state_q;
    end

endmodule

// File: rtl/pwmg_prescale.sv
module pwmg_prescale #(
    parameter int unsigned PS_W  = 3,
    parameter int unsigned PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             base_tick,
    input  logic [PS_W-1:0]  ps,
    output logic             tick_o,
    output logic [PRE_W-1:0] pre_o
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last_val;

    // last prescaler value before a step tick: 2^ps - 1
    assign last_val = ~({PRE_W{1'b1}} << ps);
    assign tick_o   = count_en && base_tick && (pre_q == last_val);
    assign pre_o    = pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!count_en) begin
            pre_q <= '0;
        end else if (base_tick) begin
            pre_q <= tick_o ? '0 : pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwmg_wave.sv
module pwmg_wave
    import pwmg_pkg::*;
#(
    parameter int unsigned STEP_W = DUTY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic              tick,
    input  logic              load,
    input  pwmg_cfg_t         cfg_live,
    output logic              pwm_o,
    output logic              wrap_o,
    output logic [STEP_W-1:0] cnt_o,
    output pwmg_cfg_t         shadow_o
);

    logic [STEP_W-1:0] cnt_q;
    pwmg_cfg_t         shadow_q;
    logic              active;
    logic              pol_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!count_en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (load) begin
            shadow_q <= cfg_live;
        end
    end

    assign wrap_o  = tick && (cnt_q == {STEP_W{1'b1}});
    assign active  = count_en && (cnt_q < shadow_q.duty);
    assign pol_now = count_en ? shadow_q.pol : cfg_live.pol;
    assign pwm_o   = pol_now ? active : !active;

    assign cnt_o    = cnt_q;
    assign shadow_o = shadow_q;

endmodule

// File: rtl/bklt_pwm_gen.sv
module bklt_pwm_gen
    import pwmg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             src_sys,
    input  logic             slow_tick,
    input  logic             en_set,
    input  logic             en_clr,
    output logic             pwm_out,
    output logic             running
);

    pwmg_cfg_t         cfg_live;
    pwmg_cfg_t         shadow_w;
    pwmg_state_e       state_w;
    logic              base_tick;
    logic              step_tick;
    logic              wrap_w;
    logic              load_w;
    logic              count_en;
    logic [DUTY_W-1:0] cnt_w;
    logic [PRE_W-1:0]  pre_w;
    logic [3:0]        unused_cfg_bits;

    assign unused_cfg_bits = {cfg_word[7:5], cfg_word[3]};

    assign cfg_live  = pwmg_make_cfg(cfg_word[DUTY_LSB +: DUTY_W],
                                     cfg_word[POL_BIT],
                                     cfg_word[PS_W-1:0]);
    assign base_tick = src_sys ? 1'b1 : slow_tick;

    pwmg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .base_tick (base_tick),
        .wrap      (wrap_w),
        .state_o   (state_w),
        .count_en  (count_en),
        .load_o    (load_w),
        .run_o     (running)
    );

    pwmg_prescale #(
        .PS_W  (PS_W),
        .PRE_W (PRE_W)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (count_en),
        .base_tick (base_tick),
        .ps        (shadow_w.ps),
        .tick_o    (step_tick),
        .pre_o     (pre_w)
    );

    pwmg_wave #(
        .STEP_W (DUTY_W)
    ) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .tick     (step_tick),
        .load     (load_w),
        .cfg_live (cfg_live),
        .pwm_o    (pwm_out),
        .wrap_o   (wrap_w),
        .cnt_o    (cnt_w),
        .shadow_o (shadow_w)
    );

endmodule

// File: rtl/pwmg_chk.sv
module pwmg_chk
    import pwmg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pol_live,
    input logic              pwm_out,
    input logic              running,
    input pwmg_state_e       state,
    input logic [DUTY_W-1:0] cnt,
    input logic [PRE_W-1:0]  pre,
    input pwmg_cfg_t         shadow,
    input logic              load
);

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (pwm_out == !pol_live));                               // R11
    AST_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (cnt == '0 && pre == '0));                             // R11
    AST_PS_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        shadow.ps <= PS_W'(PS_MAX));                                        // R3
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(shadow));                                         // R10
    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> ($past(cnt) == {DUTY_W{1'b1}}));                 // R7
    AST_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt == {DUTY_W{1'b1}}) |-> (pwm_out == !shadow.pol));  // R4
    AST_START_FROM_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> ($past(state) == ST_ARM));                       // R6

endmodule

bind bklt_pwm_gen pwmg_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pol_live (cfg_word[4]),
    .pwm_out  (pwm_out),
    .running  (running),
    .state    (state_w),
    .cnt      (cnt_w),
    .pre      (pre_w),
    .shadow   (shadow_w),
    .load     (load_w)
);

// File: tb/sim_bklt_pwm_gen.sv
module sim_bklt_pwm_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_word = '0;
    logic        src_sys = 1'b1;
    logic        slow_tick = 1'b0;
    logic        en_set = 1'b0;
    logic        en_clr = 1'b0;
    logic        pwm_out;
    logic        running;

    int  total = 0;
    int  bad = 0;
    int  cyc = 0;
    int  ph = 0;
    bit  slow_on = 1'b0;

    always #10 clk = ~clk;

    bklt_pwm_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_word  (cfg_word),
        .src_sys   (src_sys),
        .slow_tick (slow_tick),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .pwm_out   (pwm_out),
        .running   (running)
    );

    // slow tick: one pulse every third cycle
    always @(negedge clk) begin
        ph        <= (ph == 2) ? 0 : ph + 1;
        slow_tick <= slow_on && (ph == 2);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // junk in bits 7:5 and 3 must not matter (R1)
    function automatic logic [15:0] make_cfg(int duty, bit pol, int ps);
        return {duty[7:0], 3'b101, pol, 1'b1, ps[2:0]};
    endfunction

    // start, stop in the first cycle of the period, measure that single period
    task automatic run_period(int duty, bit pol, int ps, int tmul);
        int eff, w, exp_run, exp_act, lat, runs, act;
        eff = (ps > 6) ? 6 : ps;
        w = 256 << eff;
        exp_run = w * tmul;
        exp_act = (duty << eff) * tmul;
        if (!pol) exp_act = exp_run - exp_act;
        @(negedge clk);
        cfg_word = make_cfg(duty, pol, ps);
        en_set = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            en_set = 1'b0;
            lat++;
        end while (!running && lat < 2000);
        if (tmul == 1) chk("R6", "start latency", lat, 2);
        runs = 0;
        act = 0;
        while (running && runs < exp_run + 50) begin
            runs++;
            if (pwm_out) act++;
            en_clr = (runs == 1);
            @(negedge clk);
        end
        en_clr = 1'b0;
        chk("R7 R2 R9", $sformatf("period len d=%0d p=%0d", duty, ps), runs, exp_run);
        chk("R2 R4 R5", $sformatf("active d=%0d pol=%0d p=%0d", duty, pol, ps), act, exp_act);
        chk("R11", "idle level after stop", pwm_out, !pol);
    endtask

    initial begin
        int duties[5] = '{0, 1, 128, 254, 255};
        int a1, a2, n;
        repeat (3) @(negedge clk);
        cfg_word = make_cfg(10, 1'b1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "reset status", running, 0);
        chk("R11", "reset level pol=1", pwm_out, 0);
        cfg_word = make_cfg(10, 1'b0, 0);
        @(negedge clk);
        chk("R11", "idle level pol=0", pwm_out, 1);

        // sweep over duty edges, both polarities, prescale 0..3 (R1 R2 R4 R5 R6 R7)
        for (int p = 0; p < 4; p++)
            for (int d = 0; d < 5; d++)
                for (int q = 0; q < 2; q++)
                    run_period(duties[d], q[0], p, 1);

        // R3: code 7 acts as 6
        run_period(3, 1'b1, 7, 1);

        // R9: slow source, one step per 3 cycles
        src_sys = 1'b0;
        slow_on = 1'b1;
        run_period(10, 1'b1, 0, 3);
        run_period(200, 1'b0, 1, 3);

        // R9/R6/R8: no slow ticks -> stays armed; stop cancels arming
        slow_on = 1'b0;
        repeat (4) @(negedge clk);
        en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        repeat (30) @(negedge clk);
        chk("R6 R9", "armed without ticks", running, 0);
        en_clr = 1'b1;
        @(negedge clk);
        en_clr = 1'b0;
        slow_on = 1'b1;
        repeat (20) @(negedge clk);
        chk("R8", "stop during arming", running, 0);
        slow_on = 1'b0;
        src_sys = 1'b1;

        // R8: restart during draining
        cfg_word = make_cfg(50, 1'b1, 0);
        en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        n = 0;
        while (!running && n < 100) begin @(negedge clk); n++; end
        en_clr = 1'b1;
        @(negedge clk);
        en_clr = 1'b0;
        repeat (3) @(negedge clk);
        en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        repeat (280) @(negedge clk);
        chk("R8", "restart during drain keeps running", running, 1);
        // simultaneous strobes: stop wins
        en_set = 1'b1;
        en_clr = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        en_clr = 1'b0;
        chk("R8", "still draining after both strobes", running, 1);
        repeat (300) @(negedge clk);
        chk("R8", "both strobes stop", running, 0);

        // R10: mid-period duty rewrite waits for next period
        cfg_word = make_cfg(40, 1'b1, 0);
        en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        n = 0;
        while (!running && n < 100) begin @(negedge clk); n++; end
        a1 = 0;
        a2 = 0;
        for (int i = 1; i <= 512; i++) begin
            if (pwm_out) begin
                if (i <= 256) a1++;
                else a2++;
            end
            if (i == 100) cfg_word = make_cfg(200, 1'b1, 0);
            @(negedge clk);
        end
        chk("R10", "old duty kept this period", a1, 40);
        chk("R10", "new duty next period", a2, 200);
        en_clr = 1'b1;
        @(negedge clk);
        en_clr = 1'b0;
        repeat (300) @(negedge clk);
        chk("R7", "stopped after rewrite test", running, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule